// File: doc/BRIEF.md
# Region-Policy Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a 32-bit load/store port and a line-oriented memory port. It holds 512 lines of 32 bytes. Each line keeps a 19-bit tag, a valid flag and a dirty flag. The write policy is chosen anew for every access. The choice depends on the region encoded in the top three address bits, on two control inputs that select the policy with opposite polarity, and on page attributes supplied by an external translation unit when translation is active.

A processor raises `cpu_req` with an address, a write flag and write data, then holds them until `cpu_ready` pulses. A read miss, or a copy-back write miss, first writes back a dirty victim line. It then fills the line with an eight-longword burst and completes the access from the new line. A write-through write miss does not allocate a line. Uncached accesses make exactly one memory transfer.

Top module: `dc_region_cache`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first cached read causes a line fill.
- R2: With `cache_en` low, every access makes exactly one memory transfer and allocates nothing.
- R3: For addresses whose top bits are 3'b100, `cb_p1` sets the write mode: 0 gives write-through and 1 gives copy-back. `wt_user` has no effect on these addresses.
- R4: For addresses whose top bits are 3'b0xx or 3'b110, when translation is off, `wt_user` sets the write mode: 0 gives copy-back and 1 gives write-through.
- R5: When `xlat_en` is high, an access with top bits 3'b0xx or 3'b110 is cached only if `pg_cacheable` is 1, and `pg_wt` replaces `wt_user` as the write-mode select.
- R6: Addresses with top bits 3'b101 or 3'b111 are never cached. They make one memory transfer.
- R7: A read miss fetches the line as eight beats at ascending longword addresses, ending at line base + 0x1C, and returns the requested word. A later read of the same line makes no memory transfer.
- R8: A copy-back write hit makes no memory transfer and marks the line dirty. Evicting a dirty line writes its eight words back before the fill.
- R9: A write-through write hit updates the line and makes one memory write. A write-through write miss makes one memory write and does not allocate.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `mem_addr` always carries zeros in bits [31:29], and cached lines are tagged with bits [28:10].
- R11: `cpu_ready` is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Longword address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with ready |
| cpu_ready | output | 1 | Access complete pulse |
| cache_en | input | 1 | Cache enable |
| cb_p1 | input | 1 | Write mode for region 3'b100 (1 = copy-back) |
| wt_user | input | 1 | Write mode for user/kernel translated regions (1 = write-through) |
| xlat_en | input | 1 | Address translation active |
| pg_cacheable | input | 1 | Page cacheable attribute |
| pg_wt | input | 1 | Page write-through attribute |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Physical longword address of the beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Beat accepted |

## Verification
The assertions assume that the processor holds `cpu_req`, `cpu_we`, `cpu_addr`, `cpu_wdata` and the policy inputs steady from request until the ready pulse. They also assume that `mem_ack` only answers a raised `mem_req`. The bench keeps to this. It changes inputs only on falling edges, and only between accesses. Its memory model acknowledges a beat one cycle after it sees the request and drops the acknowledge for the following cycle. All test addresses leave bit 13 clear, so the model's compact index never aliases two addresses that a test uses.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_EVICT,
        ST_FILL,
        ST_RESP
    } dc_state_e;
endpackage

// File: rtl/dc_region_policy.sv
module dc_region_policy (
    input  logic [2:0] region_bits,
    input  logic       cache_en,
    input  logic       cb_p1,
    input  logic       wt_user,
    input  logic       xlat_en,
    input  logic       pg_cacheable,
    input  logic       pg_wt,
    output logic       cacheable,
    output logic       write_through
);
    always_comb begin
        cacheable     = 1'b0;
        write_through = 1'b0;
        case (region_bits)
            3'b100: begin
                cacheable     = cache_en;
                write_through = !cb_p1;
            end
            3'b101, 3'b111: begin
                cacheable     = 1'b0;
                write_through = 1'b0;
            end
            default: begin
                cacheable     = cache_en && (!xlat_en || pg_cacheable);
                write_through = xlat_en ? pg_wt : wt_user;
            end
        endcase
    end

    // R6
    always_comb begin
        uncached_region_chk: assert ((region_bits != 3'b101 && region_bits != 3'b111) || !cacheable);
    end
endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
    parameter int LINES  = 512,
    parameter int TAG_W  = 19,
    parameter int LINE_W = 256,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_line
);
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    // R8
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dirty) |-> wr_valid);
endmodule

// File: rtl/dc_region_cache.sv
module dc_region_cache #(
    parameter int LINES      = 512,
    parameter int LINE_BYTES = 32,
    parameter int DATA_W     = 32,
    parameter int PHYS_W     = 29,
    parameter int TAG_W      = 19
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_ready,
    input  logic        cache_en,
    input  logic        cb_p1,
    input  logic        wt_user,
    input  logic        xlat_en,
    input  logic        pg_cacheable,
    input  logic        pg_wt,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    import dc_pkg::*;

    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(WORDS);
    localparam int LINE_W = WORDS * DATA_W;
    localparam int TAG_LO = PHYS_W - TAG_W;
    localparam int HI_W   = 32 - PHYS_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

    typedef logic [WORDS-1:0][DATA_W-1:0] line_t;

    typedef struct packed {
        dc_state_e         state;
        logic [BEAT_W-1:0] beat;
        line_t             fill;
        logic [DATA_W-1:0] rdata;
        logic              ready;
    } regs_t;

    regs_t r_q, r_d;

    logic              cacheable, write_through;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  cur_tag, rd_tag;
    logic              rd_valid, rd_dirty, hit;
    line_t             rd_line, merged, filled;
    logic [BEAT_W-1:0] word_sel;
    logic              ls_we, ls_dirty;
    line_t             ls_line;

    dc_region_policy u_policy (
        .region_bits  (cpu_addr[31:29]),
        .cache_en     (cache_en),
        .cb_p1        (cb_p1),
        .wt_user      (wt_user),
        .xlat_en      (xlat_en),
        .pg_cacheable (pg_cacheable),
        .pg_wt        (pg_wt),
        .cacheable    (cacheable),
        .write_through(write_through)
    );

    dc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_tag  (rd_tag),
        .rd_valid(rd_valid),
        .rd_dirty(rd_dirty),
        .rd_line (rd_line),
        .wr_en   (ls_we),
        .wr_idx  (idx),
        .wr_tag  (cur_tag),
        .wr_valid(1'b1),
        .wr_dirty(ls_dirty),
        .wr_line (ls_line)
    );

    assign idx      = cpu_addr[OFF_W +: IDX_W];
    assign cur_tag  = cpu_addr[TAG_LO +: TAG_W];
    assign word_sel = cpu_addr[OFF_W-1 -: BEAT_W];
    assign hit      = rd_valid && (rd_tag == cur_tag);

    always_comb begin
        merged           = rd_line;
        merged[word_sel] = cpu_wdata;
        filled           = r_q.fill;
        filled[r_q.beat] = mem_rdata;
    end

    always_comb begin
        r_d      = r_q;
        ls_we    = 1'b0;
        ls_dirty = 1'b0;
        ls_line  = rd_line;
        case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cacheable) begin
                        r_d.state = ST_SINGLE;
                    end else if (hit) begin
                        if (!cpu_we) begin
                            r_d.rdata = rd_line[word_sel];
                            r_d.ready = 1'b1;
                            r_d.state = ST_RESP;
                        end else begin
                            ls_we    = 1'b1;
                            ls_line  = merged;
                            ls_dirty = write_through ? rd_dirty : 1'b1;
                            if (write_through) begin
                                r_d.state = ST_SINGLE;
                            end else begin
                                r_d.ready = 1'b1;
                                r_d.state = ST_RESP;
                            end
                        end
                    end else if (cpu_we && write_through) begin
                        r_d.state = ST_SINGLE;
                    end else begin
                        r_d.beat  = '0;
                        r_d.state = (rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_SINGLE: begin
                if (mem_ack) begin
                    if (!cpu_we) r_d.rdata = mem_rdata;
                    r_d.ready = 1'b1;
                    r_d.state = ST_RESP;
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) r_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    r_d.fill = filled;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == LAST_BEAT) begin
                        ls_we     = 1'b1;
                        ls_line   = filled;
                        ls_dirty  = 1'b0;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: begin
                r_d.ready = 1'b0;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, beat: '0, fill: '0, rdata: '0, ready: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req   = (r_q.state == ST_SINGLE) || (r_q.state == ST_EVICT) || (r_q.state == ST_FILL);
        mem_we    = (r_q.state == ST_EVICT) || ((r_q.state == ST_SINGLE) && cpu_we);
        mem_wdata = (r_q.state == ST_EVICT) ? rd_line[r_q.beat] : cpu_wdata;
        case (r_q.state)
            ST_EVICT: mem_addr = {HI_W'(0), rd_tag, cpu_addr[TAG_LO-1:OFF_W], r_q.beat, 2'b00};
            ST_FILL:  mem_addr = {HI_W'(0), cpu_addr[PHYS_W-1:OFF_W], r_q.beat, 2'b00};
            default:  mem_addr = {HI_W'(0), cpu_addr[PHYS_W-1:0]};
        endcase
    end

    assign cpu_rdata = r_q.rdata;
    assign cpu_ready = r_q.ready;

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10
    phys_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[31:29] == 3'b000));

    // R8
    evict_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_EVICT) |-> (mem_req && mem_we));
endmodule

// File: tb/dc_region_cache_bench.sv
module dc_region_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready;
    logic        cache_en = 1'b0, cb_p1 = 1'b0, wt_user = 1'b0;
    logic        xlat_en = 1'b0, pg_cacheable = 1'b0, pg_wt = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_addr = '0;
    logic        done = 1'b0;
    logic [31:0] mem [4096];

    always #10 clk = ~clk;

    dc_region_cache u_dc_region_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cache_en(cache_en), .cb_p1(cb_p1),
        .wt_user(wt_user), .xlat_en(xlat_en), .pg_cacheable(pg_cacheable),
        .pg_wt(pg_wt), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic int midx(input logic [31:0] a);
        return int'({a[14], a[12:2]});
    endfunction

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return 32'h5A00_0000 + 32'(midx(a));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            last_addr <= mem_addr;
            if (mem_we) begin
                mem[midx(mem_addr)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[midx(mem_addr)];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ready);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        check(!cpu_ready, "R11", 32'(cpu_ready), 32'h0);
    endtask

    task automatic t_reset();
        check(!cpu_ready, "R1", 32'(cpu_ready), 0);
        check(!mem_req, "R1", 32'(mem_req), 0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        cache_en = 1'b0;
        access(1'b0, 32'h0000_0100, '0, d);
        check(d == init_val(32'h100), "R2", d, init_val(32'h100));
        check(rd_cnt == 1, "R2", 32'(rd_cnt), 1);
        access(1'b0, 32'h0000_0100, '0, d);
        check(rd_cnt == 1, "R2", 32'(rd_cnt), 1);
    endtask

    task automatic t_fill_hit();
        logic [31:0] d;
        cache_en = 1'b1; wt_user = 1'b0; cb_p1 = 1'b1;
        access(1'b0, 32'h0000_0104, '0, d);
        check(rd_cnt == 8, "R1", 32'(rd_cnt), 8);
        check(d == init_val(32'h104), "R7", d, init_val(32'h104));
        check(last_addr == 32'h0000_011C, "R7", last_addr, 32'h11C);
        access(1'b0, 32'h0000_0118, '0, d);
        check(rd_cnt == 0, "R7", 32'(rd_cnt), 0);
        check(d == init_val(32'h118), "R7", d, init_val(32'h118));
    endtask

    task automatic t_copyback();
        logic [31:0] d;
        access(1'b1, 32'h0000_0108, 32'hDEAD_0001, d);
        check(wr_cnt == 0 && rd_cnt == 0, "R4", 32'(wr_cnt + rd_cnt), 0);
        check(mem[midx(32'h108)] == init_val(32'h108), "R8", mem[midx(32'h108)], init_val(32'h108));
        access(1'b0, 32'h0000_0108, '0, d);
        check(d == 32'hDEAD_0001, "R8", d, 32'hDEAD_0001);
        access(1'b0, 32'h0000_4100, '0, d);
        check(wr_cnt == 8, "R8", 32'(wr_cnt), 8);
        check(rd_cnt == 8, "R8", 32'(rd_cnt), 8);
        check(mem[midx(32'h108)] == 32'hDEAD_0001, "R8", mem[midx(32'h108)], 32'hDEAD_0001);
        check(d == init_val(32'h4100), "R7", d, init_val(32'h4100));
    endtask

    task automatic t_write_through();
        logic [31:0] d;
        wt_user = 1'b1;
        access(1'b1, 32'h0000_4104, 32'hBEEF_0002, d);
        check(wr_cnt == 1 && rd_cnt == 0, "R9", 32'(wr_cnt), 1);
        check(mem[midx(32'h4104)] == 32'hBEEF_0002, "R4", mem[midx(32'h4104)], 32'hBEEF_0002);
        access(1'b0, 32'h0000_4104, '0, d);
        check(d == 32'hBEEF_0002 && rd_cnt == 0, "R9", d, 32'hBEEF_0002);
        access(1'b1, 32'h0000_0200, 32'h1234_0003, d);
        check(wr_cnt == 1 && rd_cnt == 0, "R9", 32'(wr_cnt), 1);
        access(1'b0, 32'h0000_0200, '0, d);
        check(rd_cnt == 8, "R9", 32'(rd_cnt), 8);
        check(d == 32'h1234_0003, "R9", d, 32'h1234_0003);
    endtask

    task automatic t_p1_polarity();
        logic [31:0] d;
        wt_user = 1'b1; cb_p1 = 1'b0;
        access(1'b1, 32'h8000_0300, 32'hAAAA_0004, d);
        check(wr_cnt == 1 && rd_cnt == 0, "R3", 32'(wr_cnt), 1);
        check(last_addr == 32'h0000_0300, "R10", last_addr, 32'h300);
        cb_p1 = 1'b1;
        access(1'b1, 32'h8000_0304, 32'hAAAA_0005, d);
        check(wr_cnt == 0 && rd_cnt == 8, "R3", 32'(wr_cnt), 0);
        check(mem[midx(32'h304)] == init_val(32'h304), "R3", mem[midx(32'h304)], init_val(32'h304));
        access(1'b0, 32'h8000_0304, '0, d);
        check(d == 32'hAAAA_0005 && rd_cnt == 0, "R3", d, 32'hAAAA_0005);
    endtask

    task automatic t_uncached_regions();
        logic [31:0] d;
        access(1'b0, 32'hA000_0108, '0, d);
        check(rd_cnt == 1, "R6", 32'(rd_cnt), 1);
        check(d == 32'hDEAD_0001, "R6", d, 32'hDEAD_0001);
        access(1'b0, 32'hE000_0500, '0, d);
        check(rd_cnt == 1, "R6", 32'(rd_cnt), 1);
        check(last_addr == 32'h0000_0500, "R10", last_addr, 32'h500);
    endtask

    task automatic t_translation();
        logic [31:0] d;
        xlat_en = 1'b1; pg_cacheable = 1'b0; pg_wt = 1'b0; wt_user = 1'b1;
        access(1'b0, 32'h0000_0400, '0, d);
        check(rd_cnt == 1, "R5", 32'(rd_cnt), 1);
        pg_cacheable = 1'b1;
        access(1'b0, 32'h0000_0400, '0, d);
        check(rd_cnt == 8, "R5", 32'(rd_cnt), 8);
        access(1'b1, 32'h0000_0404, 32'h5555_0006, d);
        check(wr_cnt == 0, "R5", 32'(wr_cnt), 0);
        pg_wt = 1'b1; wt_user = 1'b0;
        access(1'b1, 32'h0000_0408, 32'h5555_0007, d);
        check(wr_cnt == 1, "R5", 32'(wr_cnt), 1);
        xlat_en = 1'b0;
    endtask

    task automatic t_p3();
        logic [31:0] d;
        wt_user = 1'b0;
        access(1'b1, 32'hC000_0600, 32'h7777_0008, d);
        check(wr_cnt == 0 && rd_cnt == 8, "R4", 32'(rd_cnt), 8);
        access(1'b0, 32'hC000_0600, '0, d);
        check(d == 32'h7777_0008 && rd_cnt == 0, "R4", d, 32'h7777_0008);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h5A00_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_fill_hit();
        t_copyback();
        t_write_through();
        t_p1_polarity();
        t_uncached_regions();
        t_translation();
        t_p3();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule